// File: doc/BRIEF.md
# Column Group Data Loader with Cascaded Token

This block is the digital front end of a display column driver. Pixel words of 18 bits (three 6-bit sub-pixel codes) arrive on every clock. A single-token pointer decides which group of three adjacent columns takes the current word. The token is started by a start pulse on one of two token pins, and it can walk upward from the lowest column or downward from the highest. When the token leaves the last group, a one-clock carry pulse goes out on the other token pin to start the next driver in a cascade.

A separate strobe copies the whole filled data register into an output latch, which holds one code per column for the converters. The same strobe also clears the pointer. The incoming codes can be inverted bitwise as they are stored. A narrow mode leaves out the nine middle columns, so that 300 columns are used instead of 309, and it shortens the carry timing to match.

The column count follows from the group count (103 groups of 3). The columns are numbered from 1 in this brief. Column c sits at `col_code[(c-1)*6 +: 6]` and `col_valid[c-1]`.

Top module: `colgrp_loader`

## Requirements
- R1: Within a captured word, `pix[5:0]` goes to the lowest-numbered column of the group, `pix[11:6]` to the middle column and `pix[17:12]` to the highest. Bit 0 of each code is its LSB.
- R2: With `dir_up` high, the start pulse is taken from `tok_r_in`. The clock edge that samples the start pulse captures into columns 1-3, and each following edge captures into the next group up.
- R3: With `dir_up` low, the start pulse is taken from `tok_l_in`. The first edge captures into columns 307-309, and the fill proceeds downward one group per edge.
- R4: With `narrow` low, the carry pulse is high for exactly one clock, after the 103rd edge (the start-sampling edge counts as the 1st). It appears on `tok_l_out` when `dir_up` is high and on `tok_r_out` when `dir_up` is low.
- R5: With `narrow` high, columns 151-159 are never written. The fill jumps over them in either direction, and the carry pulse follows the 100th edge.
- R6: A code is stored bitwise inverted when `inv` is high at its capture edge, and unchanged when `inv` is low.
- R7: On the first clock with `strobe` high after a clock with it low, the data register as it stood before that edge is copied into `col_code`. The copy is visible after that edge and is held until the next such edge.
- R8: The strobe edge captures no data and clears the pointer. A start pulse sampled on that same edge is ignored, no carry follows, and later edges capture nothing until a new start pulse arrives.
- R9: Edges after the token has left the last group and before the next start pulse leave the data register unchanged.
- R10: `tok_r_oe` equals the inverse of `dir_up` and `tok_l_oe` equals `dir_up`. The undriven pin's output stays low.
- R11: `col_valid` is registered one clock after `narrow`. It is low for columns 151-159 when `narrow` is high, and high everywhere else.
- R12: A synchronous reset clears the pointer, the carry and `col_code` (all zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_up | input | 1 | Fill direction: 1 upward, 0 downward |
| narrow | input | 1 | 1 selects 300-column mode |
| inv | input | 1 | Invert codes on capture |
| pix | input | 18 | Three 6-bit sub-pixel codes |
| strobe | input | 1 | Latch strobe, rising edge acts |
| tok_r_in | input | 1 | Right token pin, input side |
| tok_l_in | input | 1 | Left token pin, input side |
| tok_r_out | output | 1 | Right token pin, output side |
| tok_l_out | output | 1 | Left token pin, output side |
| tok_r_oe | output | 1 | Right token pin drive enable |
| tok_l_oe | output | 1 | Left token pin drive enable |
| col_code | output | 1854 | Latched codes, 6 bits per column |
| col_valid | output | 309 | Per-column valid flag |

## Verification
A strobe edge can coincide with a clock on which the token would otherwise capture, and also with a fresh start pulse. The test raises the strobe in the middle of a fill, keeps the start pin high and presents a new word on that same edge, and then clocks further words in. The first latch copy must hold exactly the groups filled before the strobe. A second strobe must show that neither the colliding word nor any later word was stored, and the carry must stay low throughout.

// File: rtl/colgrp_pkg.sv
package colgrp_pkg;
  localparam int CODE_W_DEF    = 6;
  localparam int SUBS_DEF      = 3;
  localparam int GROUPS_DEF    = 103;
  localparam int GAP_FIRST_DEF = 50;
  localparam int GAP_LEN_DEF   = 3;

  // true when a group index lies in the skipped middle band
  function automatic bit in_band(input int idx, input int first, input int len);
    return (idx >= first) && (idx < first + len);
  endfunction
endpackage

// File: rtl/colgrp_pointer.sv
module colgrp_pointer #(
  parameter int GROUPS    = colgrp_pkg::GROUPS_DEF,
  parameter int GAP_FIRST = colgrp_pkg::GAP_FIRST_DEF,
  parameter int GAP_LEN   = colgrp_pkg::GAP_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              clear,
  input  logic              narrow,
  output logic [GROUPS-1:0] sel,
  output logic              carry
);
  localparam int GAP_END = GAP_FIRST + GAP_LEN;

  logic [GROUPS-1:0] ptr_q;
  logic [GROUPS-1:0] nxt;
  logic [GROUPS-1:0] gap;

  // slot being captured on this edge, in logical fill order
  always_comb begin
    if (clear)      sel = '0;
    else if (start) sel = GROUPS'(1);
    else            sel = ptr_q;
  end

  generate
    for (genvar s = 0; s < GROUPS; s++) begin : g_slot
      localparam bit IN_GAP = colgrp_pkg::in_band(s, GAP_FIRST, GAP_LEN);
      assign gap[s] = narrow & IN_GAP;
      if (s == 0) begin : g_first
        assign nxt[s] = 1'b0;
      end else if (s == GAP_END) begin : g_land
        assign nxt[s] = ~gap[s] & (sel[s-1] | (narrow & sel[GAP_FIRST-1]));
      end else begin : g_step
        assign nxt[s] = ~gap[s] & sel[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      carry <= 1'b0;
    end else begin
      ptr_q <= nxt;
      carry <= sel[GROUPS-1];
    end
  end

  p_single_token_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr_q)) else $error("pointer holds more than one token");

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr_q == '0 && !carry)) else $error("strobe did not clear pointer");

  p_carry_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry) else $error("carry longer than one clock");

  p_gap_skip_r5: assert property (@(posedge clk) disable iff (rst)
    (narrow && $past(narrow)) |-> ((ptr_q & gap) == '0)) else $error("token entered skipped band");
endmodule

// File: rtl/colgrp_datareg.sv
module colgrp_datareg #(
  parameter int CODE_W = colgrp_pkg::CODE_W_DEF,
  parameter int SUBS   = colgrp_pkg::SUBS_DEF,
  parameter int GROUPS = colgrp_pkg::GROUPS_DEF,
  localparam int WORD_W = CODE_W * SUBS
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [GROUPS-1:0]        wr,
  input  logic                     inv,
  input  logic [WORD_W-1:0]        word_in,
  output logic [GROUPS*WORD_W-1:0] regs
);
  logic [WORD_W-1:0] mem [GROUPS];
  logic [WORD_W-1:0] wdata;

  assign wdata = inv ? ~word_in : word_in;

  always_ff @(posedge clk) begin
    for (int g = 0; g < GROUPS; g++) begin
      if (wr[g]) mem[g] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_out
      assign regs[g*WORD_W +: WORD_W] = mem[g];

      p_store_r6: assert property (@(posedge clk) disable iff (rst)
        wr[g] |=> (mem[g] == ($past(inv) ? ~$past(word_in) : $past(word_in))))
        else $error("group %0d stored wrong word", g);
    end
  endgenerate
endmodule

// File: rtl/colgrp_latch.sv
module colgrp_latch #(
  parameter int CODE_W    = colgrp_pkg::CODE_W_DEF,
  parameter int SUBS      = colgrp_pkg::SUBS_DEF,
  parameter int GROUPS    = colgrp_pkg::GROUPS_DEF,
  parameter int GAP_FIRST = colgrp_pkg::GAP_FIRST_DEF,
  parameter int GAP_LEN   = colgrp_pkg::GAP_LEN_DEF,
  localparam int COLS  = GROUPS * SUBS,
  localparam int BITS  = COLS * CODE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            narrow,
  input  logic [BITS-1:0] d_in,
  output logic [BITS-1:0] lat,
  output logic [COLS-1:0] valid
);
  localparam int GAP_COL0 = GAP_FIRST * SUBS;
  localparam int GAP_COLS = GAP_LEN * SUBS;

  logic [COLS-1:0] valid_d;

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam bit IN_GAP = colgrp_pkg::in_band(c, GAP_COL0, GAP_COLS);
      assign valid_d[c] = ~(narrow & IN_GAP);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       lat <= '0;
    else if (take) lat <= d_in;
  end

  always_ff @(posedge clk) valid <= valid_d;

  p_copy_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> (lat == $past(d_in))) else $error("latch copy mismatch");

  p_reset_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lat == '0)) else $error("latch not cleared by reset");

  p_valid_gap_r11: assert property (@(posedge clk) disable iff (rst)
    $past(narrow) |-> (!valid[GAP_COL0] && !valid[GAP_COL0+GAP_COLS-1] && valid[GAP_COL0+GAP_COLS]))
    else $error("valid flags wrong in narrow mode");
endmodule

// File: rtl/colgrp_loader.sv
module colgrp_loader #(
  parameter int CODE_W    = colgrp_pkg::CODE_W_DEF,
  parameter int SUBS      = colgrp_pkg::SUBS_DEF,
  parameter int GROUPS    = colgrp_pkg::GROUPS_DEF,
  parameter int GAP_FIRST = colgrp_pkg::GAP_FIRST_DEF,
  parameter int GAP_LEN   = colgrp_pkg::GAP_LEN_DEF,
  localparam int WORD_W = CODE_W * SUBS,
  localparam int COLS   = GROUPS * SUBS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dir_up,
  input  logic                   narrow,
  input  logic                   inv,
  input  logic [WORD_W-1:0]      pix,
  input  logic                   strobe,
  input  logic                   tok_r_in,
  input  logic                   tok_l_in,
  output logic                   tok_r_out,
  output logic                   tok_l_out,
  output logic                   tok_r_oe,
  output logic                   tok_l_oe,
  output logic [COLS*CODE_W-1:0] col_code,
  output logic [COLS-1:0]        col_valid
);
  logic                     stb_q;
  logic                     stb_rise;
  logic                     start;
  logic [GROUPS-1:0]        sel;
  logic [GROUPS-1:0]        wr;
  logic                     carry;
  logic [GROUPS*WORD_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= strobe;
  end

  assign stb_rise = strobe & ~stb_q;
  assign start    = dir_up ? tok_r_in : tok_l_in;

  colgrp_pointer #(
    .GROUPS(GROUPS), .GAP_FIRST(GAP_FIRST), .GAP_LEN(GAP_LEN)
  ) u_ptr (
    .clk(clk), .rst(rst), .start(start), .clear(stb_rise),
    .narrow(narrow), .sel(sel), .carry(carry)
  );

  // logical slot to physical group: reversed when filling downward
  generate
    for (genvar g = 0; g < GROUPS; g++) begin : g_map
      assign wr[g] = dir_up ? sel[g] : sel[GROUPS-1-g];
    end
  endgenerate

  colgrp_datareg #(
    .CODE_W(CODE_W), .SUBS(SUBS), .GROUPS(GROUPS)
  ) u_dreg (
    .clk(clk), .rst(rst), .wr(wr), .inv(inv), .word_in(pix), .regs(regs)
  );

  colgrp_latch #(
    .CODE_W(CODE_W), .SUBS(SUBS), .GROUPS(GROUPS),
    .GAP_FIRST(GAP_FIRST), .GAP_LEN(GAP_LEN)
  ) u_lat (
    .clk(clk), .rst(rst), .take(stb_rise), .narrow(narrow),
    .d_in(regs), .lat(col_code), .valid(col_valid)
  );

  assign tok_l_oe  = dir_up;
  assign tok_r_oe  = ~dir_up;
  assign tok_l_out = dir_up & carry;
  assign tok_r_out = ~dir_up & carry;

  p_no_capture_on_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    stb_rise |-> (wr == '0)) else $error("capture on strobe edge");

  p_one_group_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr)) else $error("more than one group written");
endmodule

// File: tb/colgrp_loader_test.sv
module colgrp_loader_test;
  localparam int GR = 103;

  logic clk = 1'b0;
  logic rst, dir_up, narrow, inv, strobe, tok_r_in, tok_l_in;
  logic [17:0] pix;
  logic tok_r_out, tok_l_out, tok_r_oe, tok_l_oe;
  logic [309*6-1:0] col_code;
  logic [308:0] col_valid;

  int errors = 0;
  int checks = 0;
  logic [5:0] m_code [GR][3];
  bit m_known [GR];

  always #2 clk = ~clk;

  colgrp_loader uut (
    .clk(clk), .rst(rst), .dir_up(dir_up), .narrow(narrow), .inv(inv),
    .pix(pix), .strobe(strobe), .tok_r_in(tok_r_in), .tok_l_in(tok_l_in),
    .tok_r_out(tok_r_out), .tok_l_out(tok_l_out), .tok_r_oe(tok_r_oe),
    .tok_l_oe(tok_l_oe), .col_code(col_code), .col_valid(col_valid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int slot_group(input int k, input bit up, input bit nar);
    int idx = k;
    if (nar && idx >= 50) idx += 3;
    return up ? idx : (GR - 1 - idx);
  endfunction

  task automatic compare_latch(input string tag);
    for (int g = 0; g < GR; g++) begin
      if (m_known[g]) begin
        for (int s = 0; s < 3; s++) begin
          check(col_code[(g*3+s)*6 +: 6] == m_code[g][s], tag,
                col_code[(g*3+s)*6 +: 6], m_code[g][s]);
        end
      end
    end
  endtask

  task automatic strobe_cmp(input string tag);
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
    compare_latch(tag);
    tick();
  endtask

  // nwords edges starting with the start pulse; random or fixed inversion
  task automatic load(input bit up, input bit nar, input int nwords,
                      input bit rnd_inv, input bit fix_inv, input string tag);
    int total = nar ? 100 : 103;
    logic outp;
    dir_up = up;
    narrow = nar;
    tick();
    check(tok_l_oe == up && tok_r_oe == !up, "R10 oe roles", {tok_l_oe, tok_r_oe}, {up, !up});
    for (int c = 148; c < 162; c++) begin
      bit ev = !(nar && c >= 150 && c <= 158);
      check(col_valid[c] == ev, "R11 valid flag", col_valid[c], ev);
    end
    for (int i = 0; i < nwords; i++) begin
      pix = 18'($urandom);
      inv = rnd_inv ? 1'($urandom) : fix_inv;
      tok_r_in = up && (i == 0);
      tok_l_in = !up && (i == 0);
      tick();
      if (i < total) begin
        int g = slot_group(i, up, nar);
        m_known[g] = 1'b1;
        for (int s = 0; s < 3; s++) m_code[g][s] = pix[s*6 +: 6] ^ {6{inv}};
      end
      outp = up ? tok_l_out : tok_r_out;
      if (i + 1 >= total - 1 && i + 1 <= total + 1) begin
        check(outp == (i + 1 == total), {tag, nar ? " R5 carry" : " R4 carry"}, outp, (i + 1 == total));
        check((up ? tok_r_out : tok_l_out) == 1'b0, "R10 idle pin low", up ? tok_r_out : tok_l_out, 0);
      end
    end
    tok_r_in = 1'b0;
    tok_l_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst = 1'b1; dir_up = 1'b1; narrow = 1'b0; inv = 1'b0; strobe = 1'b0;
    tok_r_in = 1'b0; tok_l_in = 1'b0; pix = '0;
    for (int g = 0; g < GR; g++) m_known[g] = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R12: reset state
    check(col_code == '0, "R12 latch cleared", col_code[63:0], 0);
    check(tok_l_out == 1'b0 && tok_r_out == 1'b0, "R12 carry cleared", {tok_l_out, tok_r_out}, 0);

    // R1 R2 R4 R9: upward wide fill with idle edges after the token leaves
    load(1'b1, 1'b0, 113, 1'b1, 1'b0, "R2 up wide");
    check(col_code == '0, "R7 latch held before strobe", col_code[63:0], 0);
    strobe_cmp("R1 R2 R9 up wide latch");

    // R3: downward wide fill, R6 all inverted
    load(1'b0, 1'b0, 106, 1'b0, 1'b1, "R3 down wide");
    strobe_cmp("R3 R6 down wide latch");

    // R5: narrow mode both directions
    load(1'b1, 1'b1, 103, 1'b1, 1'b0, "R5 up narrow");
    strobe_cmp("R5 up narrow latch");
    load(1'b0, 1'b1, 103, 1'b0, 1'b0, "R5 down narrow");
    strobe_cmp("R5 down narrow latch");

    // R6 directed: zero word inverted gives all ones in columns 1-3
    dir_up = 1'b1; narrow = 1'b0;
    tick();
    pix = '0; inv = 1'b1; tok_r_in = 1'b1;
    tick();
    tok_r_in = 1'b0; inv = 1'b0;
    for (int s = 0; s < 3; s++) m_code[0][s] = 6'h3f;
    pix = 18'h2a541;
    tick();
    m_code[1][0] = 6'h01; m_code[1][1] = 6'h15; m_code[1][2] = 6'h2a;
    tick(); tick(); tick(); tick();
    pix = '0;
    // finish this fill to leave the pointer idle
    for (int i = 0; i < 100; i++) begin
      pix = 18'($urandom);
      tick();
      if (i < 97) begin
        for (int s = 0; s < 3; s++) m_code[6+i][s] = pix[s*6 +: 6];
      end
    end
    // groups 2..5 were written with pix at those edges
    strobe = 1'b1;
    tick();
    strobe = 1'b0;
    check(col_code[17:0] == 18'h3ffff, "R6 inverted zero word", col_code[17:0], 18'h3ffff);
    check(col_code[35:18] == 18'h2a541, "R1 code order in group", col_code[35:18], 18'h2a541);
    tick();

    // R8: strobe collides with a capture edge and with a new start pulse
    load(1'b1, 1'b0, 20, 1'b1, 1'b0, "R8 partial");
    strobe = 1'b1; tok_r_in = 1'b1; pix = 18'($urandom);
    tick();
    strobe = 1'b0; tok_r_in = 1'b0;
    compare_latch("R8 latch at colliding strobe");
    for (int i = 0; i < 120; i++) begin
      pix = 18'($urandom);
      tick();
      if (i == 83 || i == 100 || i == 119)
        check(tok_l_out == 1'b0, "R8 no carry after clear", tok_l_out, 0);
    end
    strobe_cmp("R8 nothing stored after clear");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule